// File: doc/BRIEF.md
# Multiplexed BCD Digit Scanner

This block presents a latched 4-1/2 digit conversion result one digit at a time. The result has a half-digit most significant position and four full BCD digits, plus an overrange flag. The block drives five active-high digit-select lines and a shared 4-bit BCD bus. It also drives an active-low strobe, so a UART, a processor or an external latch can pick up each digit while the scan is in its settled middle.

A load pulse captures a new result. The scan then restarts at the top digit and runs down to the least significant digit without stopping. Only the first pass after a load produces strobes, which gives exactly five per result. Later passes only refresh the display.

If the captured result is overrange, the data bus reads zero. After the last strobe, all digit selects go low and the display stays dark until the sequencer pulses the release input at the start of the next reference-integrate phase. This gives the display a blinking look.

Top module: `bcd_digit_scanner`

## Requirements
- R1: `sel_o` is one-hot whenever the display is not blanked. Bit k selects digit D(k+1). The scan order is D5, D4, D3, D2, D1, and after D1 it wraps back to D5.
- R2: The D5 slot lasts 201 clocks. Each of D4 to D1 lasts 200 clocks.
- R3: `strobe_no` is low for exactly one clock in each strobed slot. In the D5 slot this is 101 clocks after D5 rises. In the other slots it is 100 clocks after the digit rises.
- R4: Only the first scan after a load carries strobes, so each load gives exactly five strobe pulses. Later scans have none.
- R5: `bcd_o` changes together with `sel_o` and carries the selected digit's field. Field k of `dig_i` is bits 4k+3..4k, and field 0 is D1.
- R6: While the latched result is overrange, `bcd_o` is 0000.
- R7: When an overrange result is latched, `sel_o` is all zero from the clock after its fifth strobe. It stays all zero until release.
- R8: A `release_i` pulse while blanked restarts the scan at D5 on the next clock, with no strobes.
- R9: The D5 code on `bcd_o` is 000x, where x is the OR of the four bits of field 4.
- R10: A `load_i` sampled on a clock edge latches `dig_i` and `ovr_i`. On the next cycle the outputs show D5 of the new result, even if the load arrives mid-scan, and a new five-strobe sequence is armed. If load and release arrive together, the load wins.
- R11: `release_i` has no effect while the display is not blanked.
- R12: After reset, D5 is selected, `bcd_o` is 0000, `strobe_no` is high and no strobes are armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Capture a new result (first clock after busy falls) |
| release_i | input | 1 | Start of the next reference-integrate phase |
| ovr_i | input | 1 | Overrange flag of the result being loaded |
| dig_i | input | 20 | Five 4-bit digit fields, field 0 = D1, field 4 = D5 |
| sel_o | output | 5 | Active-high digit selects, bit 4 = D5 |
| bcd_o | output | 4 | Positive-true BCD of the selected digit |
| strobe_no | output | 1 | Active-low data strobe |

## Verification
A reference model in the bench tracks time within the scan as a single cycle count. It is compared with every output on every clock.

The first stimulus is a plain in-range result with distinct digits, which shows that slot order and slot lengths are right and that strobes stop after one scan. The second is a result with a D5 field above one, which separates a masked half digit from a raw one. A reload in the middle of a slot checks restart and re-arming.

An overrange result held through the blank period, followed by a release, separates blanking and its exit from normal wrapping. Release pulses sent while the scan is running, and a load and release in the same cycle, show that release acts only while the display is blanked.

// File: rtl/digit_scan_pkg.sv
package digit_scan_pkg;
  localparam int unsigned DIG_W = 4;
  typedef logic [DIG_W-1:0] bcd_t;

  // half digit is 0 or 1; any nonzero field reads as 1
  function automatic bcd_t half_digit(input bcd_t f);
    return {3'b000, |f};
  endfunction
endpackage

// File: rtl/digit_scan_timer.sv
module digit_scan_timer #(
  parameter int unsigned NUM_DIGITS = 5,
  parameter int unsigned SLOT_LEN   = 200,
  parameter int unsigned MSD_EXTRA  = 1,
  parameter int unsigned STROBE_OFS = 100,
  localparam int unsigned POS_W = $clog2(NUM_DIGITS),
  localparam int unsigned CNT_W = $clog2(SLOT_LEN + MSD_EXTRA)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic             hold_i,
  output logic [POS_W-1:0] pos_o,
  output logic             mid_o,
  output logic             lsd_o
);
  localparam logic [POS_W-1:0] MSD_P    = POS_W'(NUM_DIGITS - 1);
  localparam logic [CNT_W-1:0] LAST_MSD = CNT_W'(SLOT_LEN + MSD_EXTRA - 1);
  localparam logic [CNT_W-1:0] LAST_STD = CNT_W'(SLOT_LEN - 1);
  localparam logic [CNT_W-1:0] MID_MSD  = CNT_W'(STROBE_OFS + MSD_EXTRA);
  localparam logic [CNT_W-1:0] MID_STD  = CNT_W'(STROBE_OFS);

  logic [POS_W-1:0] pos_q;
  logic [CNT_W-1:0] cnt_q;
  logic             is_msd;
  logic [CNT_W-1:0] last_cnt;

  assign is_msd   = (pos_q == MSD_P);
  assign last_cnt = is_msd ? LAST_MSD : LAST_STD;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q <= MSD_P;
      cnt_q <= '0;
    end else if (restart_i) begin
      pos_q <= MSD_P;
      cnt_q <= '0;
    end else if (!hold_i) begin
      if (cnt_q == last_cnt) begin
        cnt_q <= '0;
        pos_q <= (pos_q == '0) ? MSD_P : pos_q - 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign pos_o = pos_q;
  assign mid_o = (cnt_q == (is_msd ? MID_MSD : MID_STD));
  assign lsd_o = (pos_q == '0);
endmodule

// File: rtl/digit_scan_strobe.sv
module digit_scan_strobe (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic release_i,
  input  logic mid_i,
  input  logic lsd_i,
  input  logic ovr_i,
  output logic strobe_no,
  output logic blank_o
);
  logic armed_q, blank_q;
  logic final_strobe;

  assign final_strobe = armed_q && mid_i && lsd_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      blank_q <= 1'b0;
    end else if (load_i) begin
      armed_q <= 1'b1;
      blank_q <= 1'b0;
    end else if (blank_q) begin
      if (release_i) blank_q <= 1'b0;
    end else if (final_strobe) begin
      armed_q <= 1'b0;
      blank_q <= ovr_i;
    end
  end

  assign strobe_no = !(armed_q && mid_i);
  assign blank_o   = blank_q;
endmodule

// File: rtl/digit_scan_data.sv
module digit_scan_data
  import digit_scan_pkg::*;
#(
  parameter int unsigned NUM_DIGITS = 5,
  localparam int unsigned POS_W = $clog2(NUM_DIGITS)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        load_i,
  input  logic                        ovr_i,
  input  logic [NUM_DIGITS*DIG_W-1:0] dig_i,
  input  logic [POS_W-1:0]            pos_i,
  input  logic                        blank_i,
  output logic                        ovr_o,
  output bcd_t                        bcd_o
);
  bcd_t dig_q [NUM_DIGITS];
  logic ovr_q;

  for (genvar k = 0; k < NUM_DIGITS; k++) begin : g_field
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     dig_q[k] <= '0;
      else if (load_i) dig_q[k] <= dig_i[k*DIG_W +: DIG_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ovr_q <= 1'b0;
    else if (load_i) ovr_q <= ovr_i;
  end

  always_comb begin
    bcd_o = '0;
    for (int k = 0; k < NUM_DIGITS; k++) begin
      if (pos_i == POS_W'(k))
        bcd_o = (k == NUM_DIGITS - 1) ? half_digit(dig_q[k]) : dig_q[k];
    end
    if (ovr_q || blank_i) bcd_o = '0;
  end

  assign ovr_o = ovr_q;
endmodule

// File: rtl/bcd_digit_scanner.sv
module bcd_digit_scanner
  import digit_scan_pkg::*;
#(
  parameter int unsigned NUM_DIGITS = 5,
  parameter int unsigned SLOT_LEN   = 200,
  parameter int unsigned MSD_EXTRA  = 1,
  parameter int unsigned STROBE_OFS = 100,
  localparam int unsigned POS_W = $clog2(NUM_DIGITS)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        load_i,
  input  logic                        release_i,
  input  logic                        ovr_i,
  input  logic [NUM_DIGITS*DIG_W-1:0] dig_i,
  output logic [NUM_DIGITS-1:0]       sel_o,
  output logic [DIG_W-1:0]            bcd_o,
  output logic                        strobe_no
);
  logic [POS_W-1:0] pos;
  logic             mid, lsd, blank, ovr_q, restart;

  assign restart = load_i || (blank && release_i);

  digit_scan_timer #(
    .NUM_DIGITS(NUM_DIGITS), .SLOT_LEN(SLOT_LEN),
    .MSD_EXTRA(MSD_EXTRA), .STROBE_OFS(STROBE_OFS)
  ) i_timer (
    .clk_i, .rst_ni, .restart_i(restart), .hold_i(blank),
    .pos_o(pos), .mid_o(mid), .lsd_o(lsd)
  );

  digit_scan_strobe i_strobe (
    .clk_i, .rst_ni, .load_i, .release_i, .mid_i(mid), .lsd_i(lsd),
    .ovr_i(ovr_q), .strobe_no, .blank_o(blank)
  );

  digit_scan_data #(.NUM_DIGITS(NUM_DIGITS)) i_data (
    .clk_i, .rst_ni, .load_i, .ovr_i, .dig_i, .pos_i(pos),
    .blank_i(blank), .ovr_o(ovr_q), .bcd_o
  );

  for (genvar k = 0; k < NUM_DIGITS; k++) begin : g_sel
    assign sel_o[k] = !blank && (pos == POS_W'(k));
  end
endmodule

// File: rtl/digit_scan_chk.sv
module digit_scan_chk #(
  parameter int unsigned NUM_DIGITS = 5
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  load_i,
  input logic                  release_i,
  input logic                  blank_i,
  input logic                  ovr_i,
  input logic [NUM_DIGITS-1:0] sel_i,
  input logic [3:0]            bcd_i,
  input logic                  strobe_ni
);
  a_r1_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !blank_i |-> $countones(sel_i) == 1);
  a_r3_single_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_ni |=> strobe_ni);
  a_r6_ovr_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_i |-> bcd_i == 4'd0);
  a_r7_dark: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blank_i |-> sel_i == '0);
  a_r7_stay_dark: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == '0 && !release_i && !load_i) |=> sel_i == '0);
  a_r8_resume: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blank_i && release_i) |=> sel_i[NUM_DIGITS-1] && strobe_ni);
  a_r9_half_digit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_i[NUM_DIGITS-1] |-> bcd_i[3:1] == 3'd0);
  a_r10_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> sel_i[NUM_DIGITS-1] && strobe_ni);
endmodule

bind bcd_digit_scanner digit_scan_chk #(.NUM_DIGITS(NUM_DIGITS)) i_chk (
  .clk_i, .rst_ni, .load_i, .release_i, .blank_i(blank), .ovr_i(ovr_q),
  .sel_i(sel_o), .bcd_i(bcd_o), .strobe_ni(strobe_no)
);

// File: tb/test_bcd_digit_scanner.sv
module test_bcd_digit_scanner;
  localparam int CLK_PERIOD = 10;
  localparam int SCAN = 1001;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        load_i = 1'b0, release_i = 1'b0, ovr_i = 1'b0;
  logic [19:0] dig_i = '0;
  logic [4:0]  sel_o;
  logic [3:0]  bcd_o;
  logic        strobe_no;

  int checks = 0, fails = 0, strobes = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  bcd_digit_scanner i_bcd_digit_scanner (
    .clk_i, .rst_ni, .load_i, .release_i, .ovr_i, .dig_i,
    .sel_o, .bcd_o, .strobe_no
  );

  // reference model: time within scan as one count
  int          m_t = 0;
  bit          m_first = 0, m_blank = 0, m_ovr = 0;
  logic [19:0] m_data = '0;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_t = 0; m_first = 0; m_blank = 0; m_ovr = 0; m_data = '0;
    end else if (load_i) begin
      m_t = 0; m_first = 1; m_blank = 0; m_ovr = ovr_i; m_data = dig_i;
    end else if (m_blank) begin
      if (release_i) begin m_blank = 0; m_t = 0; end
    end else begin
      if (m_first && m_t == 901) begin
        m_first = 0;
        m_blank = m_ovr;
      end
      if (!m_blank) m_t = (m_t + 1) % SCAN;
    end
  end

  function automatic int idx_of(int t);
    return (t < 201) ? 4 : 3 - (t - 201) / 200;
  endfunction

  function automatic logic [4:0] exp_sel();
    return m_blank ? 5'd0 : 5'(1 << idx_of(m_t));
  endfunction

  function automatic logic [3:0] exp_bcd();
    int i = idx_of(m_t);
    if (m_blank || m_ovr) return 4'd0;
    if (i == 4) return {3'b000, |m_data[19:16]};
    return m_data[i*4 +: 4];
  endfunction

  function automatic logic exp_stb();
    int i = idx_of(m_t);
    int mid = (i == 4) ? 101 : 201 + (3 - i) * 200 + 100;
    return !(m_first && !m_blank && m_t == mid);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      chk("R1 R2 sel", 32'(sel_o), 32'(exp_sel()));
      chk("R5 bcd", 32'(bcd_o), 32'(exp_bcd()));
      chk("R3 strobe", 32'(strobe_no), 32'(exp_stb()));
      if (!strobe_no) strobes++;
    end
  end

  task automatic load(logic [19:0] d, logic o);
    load_i = 1'b1; dig_i = d; ovr_i = o;
    @(negedge clk_i);
    load_i = 1'b0; ovr_i = 1'b0;
    strobes = 0;
  endtask

  task automatic pulse_release();
    release_i = 1'b1;
    @(negedge clk_i);
    release_i = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R12 reset state
    chk("R12 sel", 32'(sel_o), 32'h10);
    chk("R12 bcd", 32'(bcd_o), 32'h0);
    chk("R12 strobe", 32'(strobe_no), 32'h1);
    rst_ni = 1'b1;
    repeat (SCAN + 5) @(negedge clk_i);
    chk("R12 no strobe before load", 32'(strobes), 32'd0);

    // R4 R5 pattern A: distinct digits
    load(20'h1_4_3_2_5, 1'b0);
    chk("R10 D5 after load", 32'(sel_o), 32'h10);
    repeat (SCAN * 3) @(negedge clk_i);
    chk("R4 five strobes", 32'(strobes), 32'd5);

    // R11 release ignored while scanning
    repeat (37) @(negedge clk_i);
    pulse_release();
    repeat (250) @(negedge clk_i);
    pulse_release();
    repeat (20) @(negedge clk_i);

    // R9 D5 field above one
    load(20'hA_9_0_7_8, 1'b0);
    chk("R9 D5 code", 32'(bcd_o), 32'h1);
    repeat (450) @(negedge clk_i);

    // R10 mid-scan reload
    load(20'h0_6_5_4_3, 1'b0);
    chk("R10 restart sel", 32'(sel_o), 32'h10);
    chk("R10 new D5", 32'(bcd_o), 32'h0);
    repeat (SCAN * 2) @(negedge clk_i);
    chk("R4 R10 re-armed", 32'(strobes), 32'd5);

    // R6 R7 R8 overrange
    load(20'h1_9_9_9_9, 1'b1);
    chk("R6 bcd zero", 32'(bcd_o), 32'h0);
    repeat (SCAN + 300) @(negedge clk_i);
    chk("R7 blanked", 32'(sel_o), 32'h0);
    chk("R6 blank bcd", 32'(bcd_o), 32'h0);
    chk("R4 ovr strobes", 32'(strobes), 32'd5);
    pulse_release();
    chk("R8 resume D5", 32'(sel_o), 32'h10);
    repeat (SCAN + 200) @(negedge clk_i);
    chk("R8 no new strobes", 32'(strobes), 32'd5);

    // R10 load beats release in the same cycle
    load(20'h1_9_9_9_9, 1'b1);
    repeat (SCAN) @(negedge clk_i);
    release_i = 1'b1;
    load(20'h0_1_2_3_4, 1'b0);
    release_i = 1'b0;
    chk("R10 load wins", 32'(sel_o), 32'h10);
    repeat (SCAN + 100) @(negedge clk_i);
    chk("R10 strobes after load", 32'(strobes), 32'd5);

    finish_run();
  end
endmodule